// File: doc/BRIEF.md
# Dithered Digital Pulse-Width Modulator

This block produces the gate-drive pulse of a switching converter from a 10-bit duty command without a fast counter clock. A delay ring, modelled here as a bus of 32 phase taps, splits each switching period into 32 equal slots. The upper five bits of the command pick the tap where the pulse ends. The lower five bits add a fractional step: a five-bit sequence counter raises the coarse code by one in a chosen subset of every 32 periods, so the pulse width averaged over 32 periods has ten bits of resolution. This duty step is finer than the feedback quantisation bin, so the loop does not settle into a limit cycle.

The command is captured once per period, on the clock edge where `period_end_i` is high. `period_end_i` is high in the last slot of each period. Two override inputs from the controller hold the output fully on or fully off whatever the command. Tap bus encoding: `phase_i[j]` is high once `j` slots of the current period have elapsed. Tap 0 is therefore high for the whole period, and the bus reads as a thermometer code that rises with the phase.

Top module: `dpwm_dither_gen`

## Requirements
- R1: While reset is low and after it, until the first period boundary, the effective code is 0, the sequence counter is 0 and `pwm_o` is low (with no override active).
- R2: With dither disabled, `pwm_o` is high in phase slots 0..c-1 and low from slot c onward, where c = `duty_i[9:5]` latched at the last boundary. The pulse ends when tap c goes high.
- R3: If the coarse code plus the dither step reaches 32, `pwm_o` stays high for the whole period.
- R4: With dither enabled and a constant command, exactly f of any 32 consecutive periods have width c+1, where f = `duty_i[4:0]`. The remaining periods have width c.
- R5: The period that starts at the n-th boundary after reset (n counted from 0) is raised if and only if the 5-bit bit-reverse of (n mod 32) is less than f. The sequence counter advances at every boundary, whether dither is enabled or not.
- R6: When `dith_en_i` is low at a boundary, the fine bits have no effect on the next period's width.
- R7: A change of `duty_i` during a period leaves that period's pulse unchanged. The new value takes effect from the next boundary.
- R8: `force_off_i` high drives `pwm_o` low at once, and takes priority over `force_on_i` and the modulated pulse.
- R9: `force_on_i` high with `force_off_i` low drives `pwm_o` high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 32 | Delay-ring phase taps, thermometer-coded |
| period_end_i | input | 1 | High in the last slot of each period |
| duty_i | input | 10 | Duty command: [9:5] coarse tap, [4:0] fine fraction |
| dith_en_i | input | 1 | Apply fine bits through the dither sequence |
| force_on_i | input | 1 | Hold output high |
| force_off_i | input | 1 | Hold output low (highest priority) |
| pwm_o | output | 1 | Gate-drive pulse |

## Verification
The assertions assume that `period_end_i` marks boundaries only, and that the effective code therefore moves only on the edge it qualifies. They also assume that the overrides act combinationally on the output. Every assertion is written so that it holds for any tap pattern, but the pulse-shape checks depend on a monotonic thermometer tap bus with tap 0 always high. The stimulus generates the tap bus from a slot index that counts 0 to 31. It raises `period_end_i` only in slot 31 and changes commands only between edges, so every input stays inside these conditions.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // Which source currently drives the gate output
  typedef enum logic [1:0] {
    SRC_MOD  = 2'd0,
    SRC_FULL = 2'd1,
    SRC_ON   = 2'd2,
    SRC_OFF  = 2'd3
  } pwm_src_e;

  // Raised-period test: the reversed sequence value compared with the fraction
  function automatic logic dither_raise(input logic [7:0] rev, input logic [7:0] frac);
    return rev < frac;
  endfunction
endpackage

// File: rtl/dpwm_dither_seq.sv
module dpwm_dither_seq #(
  parameter int FINE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FINE_W-1:0] frac_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [FINE_W-1:0] seq_q;
  logic [FINE_W-1:0] seq_rev;

  // Bit-reversed view spreads raised periods evenly over the sequence
  for (genvar b = 0; b < FINE_W; b++) begin : g_rev
    assign seq_rev[b] = seq_q[FINE_W-1-b];
  end

  assign hit_o = en_i && dpwm_pkg::dither_raise(8'(seq_rev), 8'(frac_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     seq_q <= '0;
    else if (step_i) seq_q <= seq_q + 1'b1;
  end
endmodule

// File: rtl/dpwm_code_reg.sv
module dpwm_code_reg #(
  parameter int COARSE_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                hit_i,
  output logic [COARSE_W:0]   code_o
);
  logic [COARSE_W:0] code_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= {1'b0, coarse_i} + (COARSE_W+1)'(hit_i);
  end

  assign code_o = code_q;
endmodule

// File: rtl/dpwm_tap_select.sv
module dpwm_tap_select #(
  parameter int COARSE_W = 5
) (
  input  logic [COARSE_W:0]          code_i,
  input  logic [(1<<COARSE_W)-1:0]   phase_i,
  input  logic                       force_on_i,
  input  logic                       force_off_i,
  output logic                       pwm_o,
  output dpwm_pkg::pwm_src_e         src_o
);
  logic tap_sel;
  assign tap_sel = phase_i[code_i[COARSE_W-1:0]];

  always_comb begin
    if (force_off_i)          src_o = dpwm_pkg::SRC_OFF;
    else if (force_on_i)      src_o = dpwm_pkg::SRC_ON;
    else if (code_i[COARSE_W]) src_o = dpwm_pkg::SRC_FULL;
    else                      src_o = dpwm_pkg::SRC_MOD;
  end

  always_comb begin
    unique case (src_o)
      dpwm_pkg::SRC_OFF:  pwm_o = 1'b0;
      dpwm_pkg::SRC_ON:   pwm_o = 1'b1;
      dpwm_pkg::SRC_FULL: pwm_o = 1'b1;
      default:            pwm_o = ~tap_sel;
    endcase
  end
endmodule

// File: rtl/dpwm_dither_gen.sv
module dpwm_dither_gen #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [(1<<COARSE_W)-1:0]       phase_i,
  input  logic                           period_end_i,
  input  logic [COARSE_W+FINE_W-1:0]     duty_i,
  input  logic                           dith_en_i,
  input  logic                           force_on_i,
  input  logic                           force_off_i,
  output logic                           pwm_o
);
  localparam int DutyW = COARSE_W + FINE_W;

  logic [COARSE_W-1:0] coarse_cmd;
  logic [FINE_W-1:0]   fine_cmd;
  logic                raise_hit;
  logic [COARSE_W:0]   code_eff;
  dpwm_pkg::pwm_src_e  pwm_src;

  assign coarse_cmd = duty_i[DutyW-1:FINE_W];
  assign fine_cmd   = duty_i[FINE_W-1:0];

  dpwm_dither_seq #(.FINE_W(FINE_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (period_end_i),
    .frac_i (fine_cmd),
    .en_i   (dith_en_i),
    .hit_o  (raise_hit)
  );

  dpwm_code_reg #(.COARSE_W(COARSE_W)) u_code (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (period_end_i),
    .coarse_i (coarse_cmd),
    .hit_i    (raise_hit),
    .code_o   (code_eff)
  );

  dpwm_tap_select #(.COARSE_W(COARSE_W)) u_sel (
    .code_i      (code_eff),
    .phase_i     (phase_i),
    .force_on_i  (force_on_i),
    .force_off_i (force_off_i),
    .pwm_o       (pwm_o),
    .src_o       (pwm_src)
  );
endmodule

// File: rtl/dpwm_dither_gen_chk.sv
module dpwm_dither_gen_chk #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       period_end_i,
  input logic [COARSE_W+FINE_W-1:0] duty_i,
  input logic                       dith_en_i,
  input logic                       force_on_i,
  input logic                       force_off_i,
  input logic                       pwm_o,
  input logic [COARSE_W:0]          code_eff
);
  assert_reset_code_R1: assert property (@(posedge clk_i)
    !rst_ni |=> code_eff == '0);

  assert_hold_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> $stable(code_eff));

  assert_no_dither_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_i && !dith_en_i) |=>
      code_eff == {1'b0, $past(duty_i[COARSE_W+FINE_W-1:FINE_W])});

  assert_step_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=>
      (code_eff - {1'b0, $past(duty_i[COARSE_W+FINE_W-1:FINE_W])}) <= 1);

  assert_full_period_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (code_eff[COARSE_W] && !force_off_i) |-> pwm_o);

  assert_force_off_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    force_off_i |-> !pwm_o);

  assert_force_on_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (force_on_i && !force_off_i) |-> pwm_o);
endmodule

bind dpwm_dither_gen dpwm_dither_gen_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .period_end_i (period_end_i),
  .duty_i       (duty_i),
  .dith_en_i    (dith_en_i),
  .force_on_i   (force_on_i),
  .force_off_i  (force_off_i),
  .pwm_o        (pwm_o),
  .code_eff     (code_eff)
);

// File: tb/dpwm_dither_gen_tb.sv
module dpwm_dither_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] phase = 32'h1;
  logic        pend = 1'b0;
  logic [9:0]  duty = '0;
  logic        den = 1'b0;
  logic        fon = 1'b0;
  logic        foff = 1'b0;
  logic        pwm;

  int checks = 0;
  int errors = 0;
  int nper = 0;       // boundaries seen since reset
  int exp_code = 0;   // width expected in the current period

  always #4 clk = ~clk;

  dpwm_dither_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .period_end_i(pend),
    .duty_i(duty), .dith_en_i(den), .force_on_i(fon), .force_off_i(foff),
    .pwm_o(pwm)
  );

  function automatic int rev5(input int v);
    int r = 0;
    for (int i = 0; i < 5; i++) if (v[i]) r += 1 << (4 - i);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full period; returns measured high slots and whether shape matched model
  task automatic run_period(output int hi, output bit shape_ok,
                            input int mid_ph = -1, input logic [9:0] mid_duty = '0);
    int next_code;
    hi = 0; shape_ok = 1'b1;
    for (int ph = 0; ph < 32; ph++) begin
      bit expv;
      @(negedge clk);
      for (int j = 0; j < 32; j++) phase[j] = (ph >= j);
      pend = (ph == 31);
      if (ph == mid_ph) duty = mid_duty;
      #1;
      expv = foff ? 1'b0 : (fon ? 1'b1 : (ph < exp_code));
      if (pwm !== expv) shape_ok = 1'b0;
      if (pwm === 1'b1) hi++;
      if (ph == 31) begin
        next_code = int'(duty[9:5]) + ((den && rev5(nper % 32) < int'(duty[4:0])) ? 1 : 0);
      end
    end
    @(posedge clk);
    nper++;
    exp_code = next_code;
    #1 pend = 1'b0;
  endtask

  task automatic t_reset();
    int hi; bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwm === 1'b0, "R1 reset output", pwm, 0);
    rst_n = 1'b1;
    run_period(hi, ok);
    check(ok && hi == 0, "R1 first period low", hi, 0);
  endtask

  task automatic t_coarse();
    int hi; bit ok;
    logic [4:0] cs [3] = '{5'd7, 5'd0, 5'd31};
    den = 1'b0;
    foreach (cs[k]) begin
      duty = {cs[k], 5'd0};
      run_period(hi, ok);            // boundary latches the new code
      run_period(hi, ok);
      check(ok && hi == int'(cs[k]), "R2 coarse width", hi, int'(cs[k]));
    end
  endtask

  task automatic t_no_dither();
    int hi; bit ok;
    den = 1'b0; duty = {5'd12, 5'd31};
    run_period(hi, ok);
    for (int k = 0; k < 4; k++) begin
      run_period(hi, ok);
      check(ok && hi == 12, "R6 fine ignored", hi, 12);
    end
  endtask

  task automatic t_dither(input logic [4:0] c, input logic [4:0] f);
    int hi, raised; bit ok;
    den = 1'b1; duty = {c, f};
    run_period(hi, ok);
    raised = 0;
    for (int k = 0; k < 32; k++) begin
      int e = exp_code;
      run_period(hi, ok);
      check(ok && hi == e, "R5 per-period width", hi, e);
      if (hi == int'(c) + 1) raised++;
    end
    check(raised == int'(f), "R4 raised periods in 32", raised, int'(f));
  endtask

  task automatic t_overflow();
    int hi, full; bit ok;
    den = 1'b1; duty = {5'd31, 5'd31};
    run_period(hi, ok);
    full = 0;
    for (int k = 0; k < 32; k++) begin
      int e = exp_code;
      run_period(hi, ok);
      if (e == 32) check(ok && hi == 32, "R3 full period high", hi, 32);
      if (hi == 32) full++;
    end
    check(full == 31, "R3 full periods in 32", full, 31);
  endtask

  task automatic t_midchange();
    int hi; bit ok;
    den = 1'b0; duty = {5'd20, 5'd0};
    run_period(hi, ok);
    run_period(hi, ok, 5, {5'd3, 5'd0});
    check(ok && hi == 20, "R7 mid-period change held off", hi, 20);
    run_period(hi, ok);
    check(ok && hi == 3, "R7 new command next period", hi, 3);
  endtask

  task automatic t_force();
    int hi; bit ok;
    den = 1'b0; duty = {5'd16, 5'd0};
    run_period(hi, ok);
    foff = 1'b1; fon = 1'b1;
    run_period(hi, ok);
    check(ok && hi == 0, "R8 force off wins", hi, 0);
    fon = 1'b0;
    duty = {5'd31, 5'd0};
    run_period(hi, ok);
    check(ok && hi == 0, "R8 force off over pulse", hi, 0);
    foff = 1'b0; fon = 1'b1; duty = '0;
    run_period(hi, ok);
    check(ok && hi == 32, "R9 force on", hi, 32);
    fon = 1'b0;
    run_period(hi, ok);
    check(ok && hi == 0, "R9 release to zero code", hi, 0);
  endtask

  initial begin
    t_reset();
    t_coarse();
    t_no_dither();
    t_dither(5'd10, 5'd5);
    t_dither(5'd0, 5'd17);
    t_overflow();
    t_midchange();
    t_force();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule